// File: doc/BRIEF.md
# Timed Serial Register Writer

This block is the host side of a four-wire serial link to a peripheral with 8-bit internal registers. A command interface with valid and ready hands over one byte at a time. The block then lowers chip select and sends the byte on the data-out line, most significant bit first. Each bit gets one clock pulse. The byte the peripheral shifts back on its data-in line is collected. Every edge-to-edge delay the peripheral requires is counted in system clock cycles, and each delay is a parameter. The peripheral latches data on the falling clock edge, so the block changes its data-out line only on the rising edge.

The block also drives an integrate/hold control line. A raised line must wait until a guard time has passed since the last chip select rise. A request that arrives too early is held and applied as soon as the guard allows. Two status outputs report the peripheral as integrating or holding. Each one appears only after that mode's settling time has passed since the control line last changed.

Top module: `ser_reg_writer`

## Requirements
- R1: While reset is applied, chip select is high, the serial clock and data-out are low, the command ready output is high, and the done strobe, integrate/hold, integrating and holding outputs are all low.
- R2: Each accepted command byte is sent as exactly 8 data-out bits, most significant first. A receiver that samples data-out on each falling serial clock edge collects the command byte.
- R3: The byte the peripheral drives on data-in is collected first bit first, one bit per falling serial clock edge. When the eighth bit lands, that byte appears on the received-data output together with a done strobe that is high for exactly one cycle.
- R4: The first rising serial clock edge of a frame comes at least CS_TO_RISE_CYC cycles after chip select falls. The first falling edge comes at least CS_TO_FALL_CYC cycles after chip select falls.
- R5: Each high phase of the serial clock lasts at least SCK_HI_CYC cycles, and each low phase between bits lasts at least SCK_LO_CYC cycles.
- R6: Data-out changes only in the cycle in which the serial clock rises. It is stable through every high phase, so it is stable around each falling edge.
- R7: Chip select rises no sooner than TAIL_CYC cycles after the eighth falling serial clock edge.
- R8: Command ready is low from acceptance through the frame and the following gap. Chip select falls again no sooner than GAP_CYC cycles after it last rose.
- R9: A request to raise integrate/hold that is pending when chip select rises is applied exactly IH_GUARD_CYC+1 cycles after that rise. With no write inside the guard window and chip select high, a request raises the line one cycle after it is asserted.
- R10: Integrate/hold falls one cycle after the request input drops.
- R11: The integrating output rises exactly INT_SETTLE_CYC cycles after integrate/hold rises. The holding output rises exactly HOLD_SETTLE_CYC cycles after it falls.
- R12: Every frame carries exactly 8 rising serial clock edges between the fall and the rise of chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_data | input | 8 | Byte to write |
| cmd_valid | input | 1 | Command byte is offered |
| cmd_ready | output | 1 | Block can accept a byte |
| ih_req | input | 1 | Request for integrate (high) or hold (low) |
| ser_cs_n | output | 1 | Serial chip select, active low |
| ser_sck | output | 1 | Serial clock, idles low |
| ser_si | output | 1 | Serial data to the peripheral |
| ser_so | input | 1 | Serial data from the peripheral |
| rx_data | output | 8 | Byte returned by the last frame |
| rx_done | output | 1 | One-cycle strobe, rx_data is fresh |
| int_hold | output | 1 | Integrate/hold control line |
| periph_integrating | output | 1 | Peripheral has settled into integration |
| periph_holding | output | 1 | Peripheral has settled into hold |

## Verification
The assertions assume that the peripheral changes data-in only between falling serial clock edges. They also assume that the integrate request is a level held long enough to matter. Neither assumption is checked. The bench peripheral model updates data-in on the sample after each falling edge it observes, and loads its first bit when chip select falls. The stimulus sweeps all 256 command bytes, each paired with a computed return byte, and toggles the request only at clock midpoints.

// File: rtl/srw_pkg.sv
// Shared types and elaboration helpers for the serial register writer.
// Assumes nothing beyond integer parameters being positive.
package srw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_GAP
    } seq_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int width_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/srw_seq.sv
// Frame sequencer: owns chip select and the serial clock, times every
// phase with one down-counter and emits strobes for the shift datapath.
// Assumes all cycle-count parameters are at least 1.
module srw_seq
    import srw_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int CS_TO_RISE_CYC = 1,
    parameter int CS_TO_FALL_CYC = 8,
    parameter int SCK_HI_CYC     = 6,
    parameter int SCK_LO_CYC     = 6,
    parameter int TAIL_CYC       = 8,
    parameter int GAP_CYC        = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    output logic cmd_ready,
    output logic cs_n,
    output logic sck,
    output logic load_stb,
    output logic rise_stb,
    output logic fall_stb,
    output logic last_stb,
    output logic cs_rise_stb
);

    localparam int LEAD_CYC = max_of(max_of(CS_TO_RISE_CYC, SCK_LO_CYC),
                                     CS_TO_FALL_CYC - SCK_HI_CYC);
    localparam int LONGEST  = max_of(max_of(max_of(LEAD_CYC, SCK_HI_CYC),
                                            max_of(SCK_LO_CYC, TAIL_CYC)),
                                     max_of(GAP_CYC, CS_TO_FALL_CYC));
    localparam int CNT_W    = width_for(LONGEST);
    localparam int IDX_W    = width_for(DATA_W - 1);
    localparam int RC_W     = width_for(DATA_W);

    localparam logic [CNT_W-1:0] LEAD_M1 = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] HI_M1   = CNT_W'(SCK_HI_CYC - 1);
    localparam logic [CNT_W-1:0] LO_M1   = CNT_W'(SCK_LO_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_M1 = CNT_W'(TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_M1  = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             cnt_zero;

    // Purpose: decode phase-end strobes from the state and counter.
    always_comb begin
        cnt_zero    = (cnt == '0);
        cmd_ready   = (state == ST_IDLE);
        load_stb    = cmd_ready && cmd_valid;
        rise_stb    = ((state == ST_LEAD) || (state == ST_LOW)) && cnt_zero;
        fall_stb    = (state == ST_HIGH) && cnt_zero;
        last_stb    = fall_stb && (bit_idx == LAST_IDX);
        cs_rise_stb = (state == ST_TAIL) && cnt_zero;
    end

    // Purpose: step through lead, bit phases, tail and gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            cs_n    <= 1'b1;
            sck     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (load_stb) begin
                        state   <= ST_LEAD;
                        cnt     <= LEAD_M1;
                        cs_n    <= 1'b0;
                        bit_idx <= '0;
                    end
                end
                ST_LEAD, ST_LOW: begin
                    if (cnt_zero) begin
                        state <= ST_HIGH;
                        cnt   <= HI_M1;
                        sck   <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt_zero) begin
                        sck <= 1'b0;
                        if (bit_idx == LAST_IDX) begin
                            state <= ST_TAIL;
                            cnt   <= TAIL_M1;
                        end else begin
                            state   <= ST_LOW;
                            cnt     <= LO_M1;
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (cnt_zero) begin
                        state <= ST_GAP;
                        cnt   <= GAP_M1;
                        cs_n  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt_zero) state <= ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker state: phase-length counters driven from the pins alone.
    logic [CNT_W-1:0] hi_run, lo_run, csl_run, hcs_run;
    logic [RC_W-1:0]  rise_cnt;
    logic             sck_q;

    // Purpose: measure high, low, chip-select-low and chip-select-high runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run   <= '0;
            lo_run   <= CNT_MAX;
            csl_run  <= '0;
            hcs_run  <= CNT_MAX;
            rise_cnt <= '0;
            sck_q    <= 1'b0;
        end else begin
            sck_q   <= sck;
            hi_run  <= !sck ? '0 : (hi_run == CNT_MAX ? hi_run : hi_run + 1'b1);
            lo_run  <= sck  ? '0 : (lo_run == CNT_MAX ? lo_run : lo_run + 1'b1);
            csl_run <= cs_n ? '0 : (csl_run == CNT_MAX ? csl_run : csl_run + 1'b1);
            hcs_run <= !cs_n ? '0 : (hcs_run == CNT_MAX ? hcs_run : hcs_run + 1'b1);
            if (cs_n)               rise_cnt <= '0;
            else if (sck && !sck_q) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    a_r5_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |-> hi_run >= CNT_W'(SCK_HI_CYC));
    a_r5_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sck) && rise_cnt != '0) |-> lo_run >= CNT_W'(SCK_LO_CYC));
    a_r4_first_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sck) && rise_cnt == '0) |-> csl_run >= CNT_W'(CS_TO_RISE_CYC));
    a_r4_first_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sck) && rise_cnt == RC_W'(1)) |-> csl_run >= CNT_W'(CS_TO_FALL_CYC));
    a_r7_tail: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> lo_run >= CNT_W'(TAIL_CYC));
    a_r12_eight_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> rise_cnt == RC_W'(DATA_W));
    a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> hcs_run >= CNT_W'(GAP_CYC));
    a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !cmd_ready);
    a_r2_sck_framed: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

endmodule

// File: rtl/srw_shift.sv
// Shift datapath: loads the command byte, presents one bit per rising
// serial clock on data-out and collects data-in at each falling edge.
// Assumes the strobes come from srw_seq and DATA_W is at least 3.
module srw_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              load_stb,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              last_stb,
    input  logic              so,
    output logic              si,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done
);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-2:0] rx_sh;

    // Purpose: move transmit bits out and receive bits in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            si      <= 1'b0;
            rx_data <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= last_stb;
            if (load_stb) begin
                tx_sh <= cmd_data;
            end else if (rise_stb) begin
                si    <= tx_sh[DATA_W-1];
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
            if (fall_stb) rx_sh   <= {rx_sh[DATA_W-3:0], so};
            if (last_stb) rx_data <= {rx_sh, so};
        end
    end

    logic sck_hi_q;

    // Purpose: remember whether the previous cycle ended a rise strobe window.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_hi_q <= 1'b0;
        else        sck_hi_q <= rise_stb;
    end

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
    a_r6_si_only_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_hi_q |-> $stable(si));

endmodule

// File: rtl/srw_ih.sv
// Integrate/hold gate: defers a raise request until a guard time after
// the last chip select rise, and reports settled integrate/hold states.
// Assumes ih_req is a level and cs_rise_stb marks each chip select rise.
module srw_ih
    import srw_pkg::*;
#(
    parameter int IH_GUARD_CYC    = 800,
    parameter int INT_SETTLE_CYC  = 2000,
    parameter int HOLD_SETTLE_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ih_req,
    input  logic cs_n,
    input  logic cs_rise_stb,
    output logic int_hold,
    output logic integrating,
    output logic holding
);

    localparam int GD_W = width_for(IH_GUARD_CYC);
    localparam int ST_W = width_for(max_of(INT_SETTLE_CYC, HOLD_SETTLE_CYC));
    localparam logic [GD_W-1:0] GD_LOAD = GD_W'(IH_GUARD_CYC);
    localparam logic [GD_W-1:0] GD_MAX  = {GD_W{1'b1}};
    localparam logic [ST_W-1:0] ST_MAX  = {ST_W{1'b1}};
    localparam logic [ST_W-1:0] INT_LIM = ST_W'(INT_SETTLE_CYC);
    localparam logic [ST_W-1:0] HLD_LIM = ST_W'(HOLD_SETTLE_CYC);

    logic [GD_W-1:0] guard;
    logic [ST_W-1:0] settle;
    logic            ih_nxt;

    // Purpose: raise only when the guard has expired and no frame is open.
    always_comb begin
        ih_nxt      = ih_req && (int_hold || (guard == '0 && cs_n));
        integrating = int_hold && (settle >= INT_LIM);
        holding     = !int_hold && (settle >= HLD_LIM);
    end

    // Purpose: run the guard timer, the control line and the settle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard    <= '0;
            int_hold <= 1'b0;
            settle   <= '0;
        end else begin
            if (cs_rise_stb)       guard <= GD_LOAD;
            else if (guard != '0)  guard <= guard - 1'b1;
            int_hold <= ih_nxt;
            if (ih_nxt != int_hold)  settle <= '0;
            else if (settle != ST_MAX) settle <= settle + 1'b1;
        end
    end

    logic [GD_W-1:0] since_cs;
    logic [ST_W-1:0] hi_run;

    // Purpose: checker timers driven from chip select and the control line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cs <= GD_MAX;
            hi_run   <= '0;
        end else begin
            since_cs <= !cs_n ? '0 : (since_cs == GD_MAX ? since_cs : since_cs + 1'b1);
            hi_run   <= !int_hold ? '0 : (hi_run == ST_MAX ? hi_run : hi_run + 1'b1);
        end
    end

    a_r9_guard_respected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_hold) |-> since_cs >= GD_LOAD);
    a_r10_drop_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !ih_req |=> !int_hold);
    a_r11_integrate_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(integrating) |-> hi_run >= INT_LIM);

endmodule

// File: rtl/ser_reg_writer.sv
// Top of the timed serial register writer: joins the frame sequencer,
// the shift datapath and the integrate/hold gate.
// Assumes one clock domain; all delays are given in system clock cycles.
module ser_reg_writer
    import srw_pkg::*;
#(
    parameter int DATA_W          = 8,
    parameter int CS_TO_RISE_CYC  = 1,
    parameter int CS_TO_FALL_CYC  = 8,
    parameter int SCK_HI_CYC      = 6,
    parameter int SCK_LO_CYC      = 6,
    parameter int TAIL_CYC        = 8,
    parameter int GAP_CYC         = 20,
    parameter int IH_GUARD_CYC    = 800,
    parameter int INT_SETTLE_CYC  = 2000,
    parameter int HOLD_SETTLE_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              ih_req,
    output logic              ser_cs_n,
    output logic              ser_sck,
    output logic              ser_si,
    input  logic              ser_so,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done,
    output logic              int_hold,
    output logic              periph_integrating,
    output logic              periph_holding
);

    logic load_stb, rise_stb, fall_stb, last_stb, cs_rise_stb;

    srw_seq #(
        .DATA_W(DATA_W), .CS_TO_RISE_CYC(CS_TO_RISE_CYC),
        .CS_TO_FALL_CYC(CS_TO_FALL_CYC), .SCK_HI_CYC(SCK_HI_CYC),
        .SCK_LO_CYC(SCK_LO_CYC), .TAIL_CYC(TAIL_CYC), .GAP_CYC(GAP_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cs_n(ser_cs_n), .sck(ser_sck), .load_stb(load_stb),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .last_stb(last_stb),
        .cs_rise_stb(cs_rise_stb)
    );

    srw_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .load_stb(load_stb),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .last_stb(last_stb),
        .so(ser_so), .si(ser_si), .rx_data(rx_data), .rx_done(rx_done)
    );

    srw_ih #(
        .IH_GUARD_CYC(IH_GUARD_CYC), .INT_SETTLE_CYC(INT_SETTLE_CYC),
        .HOLD_SETTLE_CYC(HOLD_SETTLE_CYC)
    ) u_ih (
        .clk(clk), .rst_n(rst_n), .ih_req(ih_req), .cs_n(ser_cs_n),
        .cs_rise_stb(cs_rise_stb), .int_hold(int_hold),
        .integrating(periph_integrating), .holding(periph_holding)
    );

    a_r3_done_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> !ser_cs_n);

endmodule

// File: tb/tb_ser_reg_writer.sv
module tb_ser_reg_writer;

    localparam int CLK_PERIOD = 10;
    localparam int CSR = 1, CSF = 8, HI = 6, LO = 6, TAIL = 8, GAP = 20;
    localparam int GUARD = 800, INT_S = 2000, HOLD_S = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       cmd_valid = 1'b0;
    logic       ih_req = 1'b0;
    logic       so_drv = 1'b0;
    logic       cmd_ready, ser_cs_n, ser_sck, ser_si, rx_done;
    logic       int_hold, periph_integrating, periph_holding;
    logic [7:0] rx_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_reg_writer dut (
        .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .ih_req(ih_req), .ser_cs_n(ser_cs_n),
        .ser_sck(ser_sck), .ser_si(ser_si), .ser_so(so_drv), .rx_data(rx_data),
        .rx_done(rx_done), .int_hold(int_hold),
        .periph_integrating(periph_integrating), .periph_holding(periph_holding)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Peripheral model and pin monitor, sampled at clock midpoints.
    int cyc = 0, t_csf = 0, t_csr = 0, t_rise = 0, t_fall = 0;
    int t_ih_r = 0, t_ih_f = 0, t_int = 0, t_hld = 0;
    int nrise = 0, nfall = 0, minhi = 0, minlo = 0, ndone = 0;
    bit seen_csr = 0, si_bad = 0, rdy_bad = 0;
    logic pcs = 1, psck = 0, psi = 0, pih = 0, pint = 0, phld = 0;
    logic [7:0] pshift = 0, pcap = 0, d_cur = 0, resp_cur = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (pcs && !ser_cs_n) begin
                if (seen_csr) chk(cyc - t_csr >= GAP, "R8 gap", cyc - t_csr, GAP);
                t_csf = cyc; nrise = 0; nfall = 0; minhi = 1 << 20; minlo = 1 << 20;
                si_bad = 0; rdy_bad = 0; pshift = resp_cur; so_drv = resp_cur[7]; pcap = 0;
            end
            if (!psck && ser_sck) begin
                if (nrise == 0) chk(cyc - t_csf >= CSR, "R4 first rise", cyc - t_csf, CSR);
                else if (cyc - t_fall < minlo) minlo = cyc - t_fall;
                t_rise = cyc; nrise++;
            end else if (ser_si != psi) si_bad = 1;
            if (psck && !ser_sck) begin
                if (cyc - t_rise < minhi) minhi = cyc - t_rise;
                if (nfall == 0) chk(cyc - t_csf >= CSF, "R4 first fall", cyc - t_csf, CSF);
                t_fall = cyc; nfall++;
                pcap = {pcap[6:0], ser_si};
                pshift = {pshift[6:0], 1'b0};
                so_drv = pshift[7];
            end
            if (!ser_cs_n && cmd_ready) rdy_bad = 1;
            if (rx_done) begin
                ndone++;
                chk(rx_data == resp_cur, "R3 returned byte", rx_data, resp_cur);
                chk(pcap == d_cur, "R2 byte seen by peripheral", pcap, d_cur);
            end
            if (!pcs && ser_cs_n) begin
                t_csr = cyc; seen_csr = 1;
                chk(cyc - t_fall >= TAIL, "R7 tail", cyc - t_fall, TAIL);
                chk(nrise == 8, "R12 rising edges", nrise, 8);
                chk(minhi >= HI, "R5 high phase", minhi, HI);
                chk(minlo >= LO, "R5 low phase", minlo, LO);
                chk(!si_bad, "R6 data-out moved off a rise", si_bad, 0);
                chk(!rdy_bad, "R8 ready during frame", rdy_bad, 0);
            end
            if (!pih && int_hold) t_ih_r = cyc;
            if (pih && !int_hold) t_ih_f = cyc;
            if (!pint && periph_integrating) t_int = cyc;
            if (!phld && periph_holding) t_hld = cyc;
        end
        pcs = ser_cs_n; psck = ser_sck; psi = ser_si;
        pih = int_hold; pint = periph_integrating; phld = periph_holding;
    end

    task automatic send(input logic [7:0] d, input logic [7:0] r);
        int n0;
        n0 = ndone;
        d_cur = d; resp_cur = r;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (ndone == n0) @(negedge clk);
        while (!ser_cs_n) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(ser_cs_n == 1, "R1 cs", ser_cs_n, 1);
        chk(ser_sck == 0 && ser_si == 0, "R1 sck/si", {ser_sck, ser_si}, 0);
        chk(cmd_ready == 1, "R1 ready", cmd_ready, 1);
        chk({rx_done, int_hold, periph_integrating, periph_holding} == 0,
            "R1 strobes and status", {rx_done, int_hold, periph_integrating, periph_holding}, 0);
        rst_n = 1'b1;
        // R2 R3 R4 R5 R6 R7 R8 R12: sweep every command byte
        for (int d = 0; d < 256; d++) send(8'(d), 8'((d * 37 + 11) % 256));
        // R9: request raised before a write; applied after the guard
        ih_req = 1'b1;
        send(8'hA5, 8'h3C);
        for (int k = 0; k < GUARD + 50 && !int_hold; k++) @(negedge clk);
        @(negedge clk);
        chk(t_ih_r - t_csr == GUARD + 1, "R9 deferred raise", t_ih_r - t_csr, GUARD + 1);
        // R11: integrating after settle time
        for (int k = 0; k < INT_S + 50 && !periph_integrating; k++) @(negedge clk);
        @(negedge clk);
        chk(t_int - t_ih_r == INT_S, "R11 integrating", t_int - t_ih_r, INT_S);
        // R10: drop follows next cycle
        ih_req = 1'b0;
        @(negedge clk);
        chk(int_hold == 0, "R10 drop", int_hold, 0);
        chk(periph_integrating == 0, "R11 integrating cleared", periph_integrating, 0);
        for (int k = 0; k < HOLD_S + 50 && !periph_holding; k++) @(negedge clk);
        @(negedge clk);
        chk(t_hld - t_ih_f == HOLD_S, "R11 holding", t_hld - t_ih_f, HOLD_S);
        // R9: idle with guard expired, raise is immediate
        ih_req = 1'b1;
        @(negedge clk);
        chk(int_hold == 1, "R9 idle raise", int_hold, 1);
        chk(periph_holding == 0, "R11 holding cleared", periph_holding, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule